// File: doc/BRIEF.md
# Store-Exclusive Halfword Unit

This block executes a store-release-exclusive of a halfword against a single-entry local exclusive monitor. A load-exclusive elsewhere in the pipeline arms the monitor with an address. The monitor drops its reservation on an explicit clear, on a plain store seen to the same reservation granule, or on any store-exclusive attempt. When the monitor still covers the target address, the unit issues a 16-bit memory write marked as a release. It then writes a status word back to the register file: zero if memory was updated and one if it was not.

The unit takes the decoded register indices and register values. Base index 31 selects the stack pointer, which must be aligned. The unit also resolves the two illegal register overlaps, status register equal to data register and status register equal to base register. For each overlap, a build-time parameter picks one response: undefined instruction, no operation, or a fixed, predictable "unknown" value. A misaligned halfword address raises an alignment fault. A parameter decides whether that fault is still raised when the exclusive check would fail anyway. All results appear one cycle after the operation strobe.

Top module: `stxh_unit`

## Requirements
- R1: One cycle after an executed, non-faulting operation, `wb_we_o` is 1 and `wb_idx_o` equals the status index. `wb_data_o` is 32'd0 if the write was issued and 32'd1 if it was not, so bits 31:1 are always zero.
- R2: `mem_we_o` and `mem_release_o` pulse one cycle after an operation only when all of the following hold: the monitor is valid, its tag matches the target address above the granule bits (granule 2^GRAN_LOG2 = 16 bytes), and there is no fault. `mem_data_o` carries bits 15:0 of the data register. While no write is issued, the address and data outputs read zero.
- R3: An arm strobe sets the monitor valid and latches the arm address's granule. A clear strobe, or a snooped plain store whose granule equals the tracked tag, clears the valid bit. Clearing wins over an arm in the same cycle.
- R4: Every executed attempt clears the monitor, whether it succeeds, fails or faults. This also wins over an arm in the same cycle. The attempt itself is judged against the state held before that cycle.
- R5: An odd target address raises `align_fault_o`. With FAULT_ON_FAIL=0 this fault is raised only when the monitor would pass; otherwise the attempt just fails with status 1. With FAULT_ON_FAIL=1 it is always raised.
- R6: Base index 31 takes the address from `sp_val_i`. If bits SP_ALIGN_LOG2-1:0 of it (3:0 by default) are not zero, a fault is raised whatever the monitor state.
- R7: A fault suppresses both the memory write and the status writeback.
- R8: When the status index equals the data index, DATA_OVL_RESP selects the response: undefined (`undef_o` pulses, nothing else), no operation (no outputs, monitor unchanged), or unknown (UNK_DATA is stored instead of the register value).
- R9: When the status index equals the base index and the base index is not 31, BASE_OVL_RESP selects undefined, no operation, or unknown (UNK_ADDR replaces the address). An undefined or no-operation outcome from the data overlap is decided first and ends the operation.
- R10: Undefined and no-operation outcomes leave the monitor unchanged. Undefined raises no fault and issues no write or writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Store-exclusive operation strobe |
| rs_idx_i | input | 5 | Status register index |
| rt_idx_i | input | 5 | Data register index |
| rn_idx_i | input | 5 | Base register index (31 = stack pointer) |
| rt_val_i | input | XLEN | Data register value |
| rn_val_i | input | XLEN | Base register value |
| sp_val_i | input | XLEN | Stack pointer value |
| mon_arm_i | input | 1 | Arm the monitor (load-exclusive) |
| mon_arm_addr_i | input | XLEN | Address to reserve |
| mon_clr_i | input | 1 | Explicit monitor clear |
| snoop_st_i | input | 1 | Plain store observed |
| snoop_addr_i | input | XLEN | Address of the observed store |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | XLEN | Write address |
| mem_data_o | output | 16 | Write halfword |
| mem_release_o | output | 1 | Release ordering on the write |
| wb_we_o | output | 1 | Status writeback enable |
| wb_idx_o | output | 5 | Status writeback index |
| wb_data_o | output | 32 | Zero-extended status |
| align_fault_o | output | 1 | Alignment fault |
| undef_o | output | 1 | Undefined instruction |

## Verification
A store-exclusive can arrive in the same cycle as an arm, a clear or a snooped store. It then competes with them for the monitor: it must be judged against the reservation held before that edge, and it must still leave the monitor empty. The bench drives an operation together with an arm, and an arm together with a clear or a matching snoop, in single cycles. It also issues an operation in the cycle right after an arm. A second operation then reveals whether the reservation survived. Three instances with different overlap and fault policies run beside one behavioural model, which is compared with every output on every clock.

// File: rtl/stxh_pkg.sv
package stxh_pkg;
  localparam int unsigned REG_IDX_W = 5;
  localparam logic [REG_IDX_W-1:0] SP_IDX = 5'd31;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned STATUS_W = 32;

  typedef enum logic [1:0] {
    OVL_UNDEF   = 2'd0,
    OVL_NOP     = 2'd1,
    OVL_UNKNOWN = 2'd2
  } ovl_resp_e;
endpackage

// File: rtl/stxh_monitor.sv
module stxh_monitor #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned GRAN_LOG2 = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] arm_addr_i,
  input  logic              clr_i,
  input  logic              snoop_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              attempt_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              pass_o
);
  localparam int unsigned TAG_W = ADDR_W - GRAN_LOG2;

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic             snoop_hit;
  logic             unused_low;

  assign snoop_hit  = snoop_i && (snoop_addr_i[ADDR_W-1:GRAN_LOG2] == tag_q);
  assign pass_o     = valid_q && (chk_addr_i[ADDR_W-1:GRAN_LOG2] == tag_q);
  assign unused_low = ^{arm_addr_i[GRAN_LOG2-1:0], snoop_addr_i[GRAN_LOG2-1:0],
                        chk_addr_i[GRAN_LOG2-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (clr_i || snoop_hit || attempt_i) begin
      valid_q <= 1'b0;
    end else if (arm_i) begin
      valid_q <= 1'b1;
      tag_q   <= arm_addr_i[ADDR_W-1:GRAN_LOG2];
    end
  end

  p_attempt_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempt_i |=> !valid_q);
  p_clear_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || snoop_hit) |=> !valid_q);
  p_arm_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !clr_i && !snoop_hit && !attempt_i)
      |=> (valid_q && tag_q == $past(arm_addr_i[ADDR_W-1:GRAN_LOG2])));
endmodule

// File: rtl/stxh_decode.sv
module stxh_decode
  import stxh_pkg::*;
#(
  parameter int unsigned XLEN          = 64,
  parameter ovl_resp_e   DATA_OVL_RESP = OVL_UNKNOWN,
  parameter ovl_resp_e   BASE_OVL_RESP = OVL_UNDEF,
  parameter logic [XLEN-1:0]   UNK_ADDR = 64'h0000_0000_0000_1A2C,
  parameter logic [HALF_W-1:0] UNK_DATA = 16'h5A3C
) (
  input  logic                 op_valid_i,
  input  logic [REG_IDX_W-1:0] rs_idx_i,
  input  logic [REG_IDX_W-1:0] rt_idx_i,
  input  logic [REG_IDX_W-1:0] rn_idx_i,
  input  logic [XLEN-1:0]      rt_val_i,
  input  logic [XLEN-1:0]      rn_val_i,
  input  logic [XLEN-1:0]      sp_val_i,
  output logic                 exec_o,
  output logic                 undef_o,
  output logic                 use_sp_o,
  output logic [XLEN-1:0]      addr_o,
  output logic [HALF_W-1:0]    data_o
);
  logic undef, nop, unk_data, unk_addr;
  logic unused_hi;

  assign unused_hi = ^rt_val_i[XLEN-1:HALF_W];

  // data overlap is resolved first; undef/nop ends decode
  always_comb begin
    undef    = 1'b0;
    nop      = 1'b0;
    unk_data = 1'b0;
    unk_addr = 1'b0;
    if (op_valid_i && rs_idx_i == rt_idx_i) begin
      case (DATA_OVL_RESP)
        OVL_UNDEF: undef    = 1'b1;
        OVL_NOP:   nop      = 1'b1;
        default:   unk_data = 1'b1;
      endcase
    end
    if (op_valid_i && !undef && !nop && rs_idx_i == rn_idx_i && rn_idx_i != SP_IDX) begin
      case (BASE_OVL_RESP)
        OVL_UNDEF: undef    = 1'b1;
        OVL_NOP:   nop      = 1'b1;
        default:   unk_addr = 1'b1;
      endcase
    end
  end

  assign exec_o   = op_valid_i && !undef && !nop;
  assign undef_o  = undef;
  assign use_sp_o = (rn_idx_i == SP_IDX);
  assign addr_o   = unk_addr ? UNK_ADDR : (use_sp_o ? sp_val_i : rn_val_i);
  assign data_o   = unk_data ? UNK_DATA : rt_val_i[HALF_W-1:0];
endmodule

// File: rtl/stxh_fault.sv
module stxh_fault #(
  parameter int unsigned SP_ALIGN_LOG2 = 4,
  parameter bit          FAULT_ON_FAIL = 1'b0
) (
  input  logic                     exec_i,
  input  logic                     use_sp_i,
  input  logic [SP_ALIGN_LOG2-1:0] sp_low_i,
  input  logic                     addr_lsb_i,
  input  logic                     pass_i,
  output logic                     fault_o
);
  logic sp_fault, hw_fault;

  assign sp_fault = use_sp_i && (|sp_low_i);

  if (FAULT_ON_FAIL) begin : g_fault_always
    assign hw_fault = addr_lsb_i;
  end else begin : g_fault_on_pass
    assign hw_fault = addr_lsb_i && pass_i;
  end

  assign fault_o = exec_i && (sp_fault || hw_fault);
endmodule

// File: rtl/stxh_unit.sv
module stxh_unit
  import stxh_pkg::*;
#(
  parameter int unsigned XLEN          = 64,
  parameter int unsigned GRAN_LOG2     = 4,
  parameter int unsigned SP_ALIGN_LOG2 = 4,
  parameter bit          FAULT_ON_FAIL = 1'b0,
  parameter ovl_resp_e   DATA_OVL_RESP = OVL_UNKNOWN,
  parameter ovl_resp_e   BASE_OVL_RESP = OVL_UNDEF,
  parameter logic [XLEN-1:0]   UNK_ADDR = 64'h0000_0000_0000_1A2C,
  parameter logic [HALF_W-1:0] UNK_DATA = 16'h5A3C
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_valid_i,
  input  logic [REG_IDX_W-1:0] rs_idx_i,
  input  logic [REG_IDX_W-1:0] rt_idx_i,
  input  logic [REG_IDX_W-1:0] rn_idx_i,
  input  logic [XLEN-1:0]      rt_val_i,
  input  logic [XLEN-1:0]      rn_val_i,
  input  logic [XLEN-1:0]      sp_val_i,
  input  logic                 mon_arm_i,
  input  logic [XLEN-1:0]      mon_arm_addr_i,
  input  logic                 mon_clr_i,
  input  logic                 snoop_st_i,
  input  logic [XLEN-1:0]      snoop_addr_i,
  output logic                 mem_we_o,
  output logic [XLEN-1:0]      mem_addr_o,
  output logic [HALF_W-1:0]    mem_data_o,
  output logic                 mem_release_o,
  output logic                 wb_we_o,
  output logic [REG_IDX_W-1:0] wb_idx_o,
  output logic [STATUS_W-1:0]  wb_data_o,
  output logic                 align_fault_o,
  output logic                 undef_o
);
  logic              exec, undef, use_sp, pass, fault;
  logic [XLEN-1:0]   addr;
  logic [HALF_W-1:0] data;
  logic              wr_ok, wb_ok;

  stxh_decode #(
    .XLEN(XLEN), .DATA_OVL_RESP(DATA_OVL_RESP), .BASE_OVL_RESP(BASE_OVL_RESP),
    .UNK_ADDR(UNK_ADDR), .UNK_DATA(UNK_DATA)
  ) u_decode (
    .op_valid_i(op_valid_i), .rs_idx_i(rs_idx_i), .rt_idx_i(rt_idx_i),
    .rn_idx_i(rn_idx_i), .rt_val_i(rt_val_i), .rn_val_i(rn_val_i),
    .sp_val_i(sp_val_i), .exec_o(exec), .undef_o(undef), .use_sp_o(use_sp),
    .addr_o(addr), .data_o(data)
  );

  stxh_monitor #(.ADDR_W(XLEN), .GRAN_LOG2(GRAN_LOG2)) u_monitor (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(mon_arm_i), .arm_addr_i(mon_arm_addr_i),
    .clr_i(mon_clr_i), .snoop_i(snoop_st_i), .snoop_addr_i(snoop_addr_i),
    .attempt_i(exec), .chk_addr_i(addr), .pass_o(pass)
  );

  stxh_fault #(.SP_ALIGN_LOG2(SP_ALIGN_LOG2), .FAULT_ON_FAIL(FAULT_ON_FAIL)) u_fault (
    .exec_i(exec), .use_sp_i(use_sp), .sp_low_i(sp_val_i[SP_ALIGN_LOG2-1:0]),
    .addr_lsb_i(addr[0]), .pass_i(pass), .fault_o(fault)
  );

  assign wr_ok = exec && pass && !fault;
  assign wb_ok = exec && !fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o      <= 1'b0;
      mem_addr_o    <= '0;
      mem_data_o    <= '0;
      mem_release_o <= 1'b0;
      wb_we_o       <= 1'b0;
      wb_idx_o      <= '0;
      wb_data_o     <= '0;
      align_fault_o <= 1'b0;
      undef_o       <= 1'b0;
    end else begin
      mem_we_o      <= wr_ok;
      mem_addr_o    <= wr_ok ? addr : '0;
      mem_data_o    <= wr_ok ? data : '0;
      mem_release_o <= wr_ok;
      wb_we_o       <= wb_ok;
      wb_idx_o      <= wb_ok ? rs_idx_i : '0;
      wb_data_o     <= {{(STATUS_W-1){1'b0}}, wb_ok && !pass};
      align_fault_o <= fault;
      undef_o       <= undef;
    end
  end

  p_status_zero_on_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (wb_we_o && wb_data_o == 32'd0));
  p_status_one_on_skip_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we_o && !mem_we_o) |-> (wb_data_o == 32'd1));
  p_write_needs_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !pass |=> !mem_we_o);
  p_write_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_addr_o[0]);
  p_fault_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |-> (!mem_we_o && !wb_we_o));
  p_undef_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (!mem_we_o && !wb_we_o && !align_fault_o));
endmodule

// File: tb/stxh_unit_tb_top.sv
module stxh_unit_tb_top;
  import stxh_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_DUT      = 3;
  localparam int WATCHDOG   = 20000;
  localparam logic [63:0] U_ADDR = 64'h0000_0000_0000_1A2C;
  localparam logic [15:0] U_DATA = 16'h5A3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        op_v = 0, arm = 0, clr = 0, snp = 0;
  logic [4:0]  rs = 0, rt = 0, rn = 0;
  logic [63:0] xt = 0, xn = 0, sp = 0, arm_a = 0, snp_a = 0;

  logic        o_we [N_DUT];
  logic [63:0] o_addr [N_DUT];
  logic [15:0] o_data [N_DUT];
  logic        o_rel [N_DUT];
  logic        o_wb [N_DUT];
  logic [4:0]  o_idx [N_DUT];
  logic [31:0] o_st [N_DUT];
  logic        o_flt [N_DUT];
  logic        o_und [N_DUT];

  stxh_unit #(.FAULT_ON_FAIL(1'b0), .DATA_OVL_RESP(OVL_UNKNOWN), .BASE_OVL_RESP(OVL_UNDEF),
              .UNK_ADDR(U_ADDR), .UNK_DATA(U_DATA)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_v), .rs_idx_i(rs), .rt_idx_i(rt),
    .rn_idx_i(rn), .rt_val_i(xt), .rn_val_i(xn), .sp_val_i(sp), .mon_arm_i(arm),
    .mon_arm_addr_i(arm_a), .mon_clr_i(clr), .snoop_st_i(snp), .snoop_addr_i(snp_a),
    .mem_we_o(o_we[0]), .mem_addr_o(o_addr[0]), .mem_data_o(o_data[0]),
    .mem_release_o(o_rel[0]), .wb_we_o(o_wb[0]), .wb_idx_o(o_idx[0]),
    .wb_data_o(o_st[0]), .align_fault_o(o_flt[0]), .undef_o(o_und[0]));

  stxh_unit #(.FAULT_ON_FAIL(1'b1), .DATA_OVL_RESP(OVL_NOP), .BASE_OVL_RESP(OVL_UNKNOWN),
              .UNK_ADDR(U_ADDR), .UNK_DATA(U_DATA)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_v), .rs_idx_i(rs), .rt_idx_i(rt),
    .rn_idx_i(rn), .rt_val_i(xt), .rn_val_i(xn), .sp_val_i(sp), .mon_arm_i(arm),
    .mon_arm_addr_i(arm_a), .mon_clr_i(clr), .snoop_st_i(snp), .snoop_addr_i(snp_a),
    .mem_we_o(o_we[1]), .mem_addr_o(o_addr[1]), .mem_data_o(o_data[1]),
    .mem_release_o(o_rel[1]), .wb_we_o(o_wb[1]), .wb_idx_o(o_idx[1]),
    .wb_data_o(o_st[1]), .align_fault_o(o_flt[1]), .undef_o(o_und[1]));

  stxh_unit #(.FAULT_ON_FAIL(1'b1), .DATA_OVL_RESP(OVL_UNDEF), .BASE_OVL_RESP(OVL_NOP),
              .UNK_ADDR(U_ADDR), .UNK_DATA(U_DATA)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_v), .rs_idx_i(rs), .rt_idx_i(rt),
    .rn_idx_i(rn), .rt_val_i(xt), .rn_val_i(xn), .sp_val_i(sp), .mon_arm_i(arm),
    .mon_arm_addr_i(arm_a), .mon_clr_i(clr), .snoop_st_i(snp), .snoop_addr_i(snp_a),
    .mem_we_o(o_we[2]), .mem_addr_o(o_addr[2]), .mem_data_o(o_data[2]),
    .mem_release_o(o_rel[2]), .wb_we_o(o_wb[2]), .wb_idx_o(o_idx[2]),
    .wb_data_o(o_st[2]), .align_fault_o(o_flt[2]), .undef_o(o_und[2]));

  // model configuration: 0 undef, 1 nop, 2 unknown
  int pol_d [N_DUT] = '{2, 1, 0};
  int pol_b [N_DUT] = '{0, 2, 1};
  bit fof   [N_DUT] = '{1'b0, 1'b1, 1'b1};

  logic        mv [N_DUT] = '{default: 1'b0};
  logic [59:0] mt [N_DUT] = '{default: '0};
  logic        e_we [N_DUT] = '{default: 1'b0};
  logic [63:0] e_addr [N_DUT] = '{default: '0};
  logic [15:0] e_data [N_DUT] = '{default: '0};
  logic        e_wb [N_DUT] = '{default: 1'b0};
  logic [4:0]  e_idx [N_DUT] = '{default: '0};
  logic [31:0] e_st [N_DUT] = '{default: '0};
  logic        e_flt [N_DUT] = '{default: 1'b0};
  logic        e_und [N_DUT] = '{default: 1'b0};

  int n_chk = 0, n_fail = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int k = 0; k < N_DUT; k++) begin
      bit undef, nop, ud, ua, ex, pass, flt;
      logic [63:0] a;
      logic [15:0] d;
      e_we[k] = 0; e_addr[k] = 0; e_data[k] = 0; e_wb[k] = 0; e_idx[k] = 0;
      e_st[k] = 0; e_flt[k] = 0; e_und[k] = 0;
      if (!rst_n) begin
        mv[k] = 0; mt[k] = 0;
      end else begin
        undef = 0; nop = 0; ud = 0; ua = 0; ex = 0;
        if (op_v) begin
          if (rs == rt) begin
            if (pol_d[k] == 0) undef = 1; else if (pol_d[k] == 1) nop = 1; else ud = 1;
          end
          if (!undef && !nop && rs == rn && rn != 5'd31) begin
            if (pol_b[k] == 0) undef = 1; else if (pol_b[k] == 1) nop = 1; else ua = 1;
          end
          e_und[k] = undef;
          ex = !undef && !nop;
          if (ex) begin
            a = ua ? U_ADDR : ((rn == 5'd31) ? sp : xn);
            d = ud ? U_DATA : xt[15:0];
            pass = mv[k] && (a[63:4] == mt[k]);
            flt = ((rn == 5'd31) && sp[3:0] != 0) || (a[0] && (pass || fof[k]));
            if (flt) e_flt[k] = 1;
            else begin
              e_wb[k] = 1; e_idx[k] = rs;
              if (pass) begin
                e_we[k] = 1; e_addr[k] = a; e_data[k] = d; e_st[k] = 0;
              end else e_st[k] = 1;
            end
          end
        end
        if (clr || (snp && snp_a[63:4] == mt[k]) || ex) mv[k] = 0;
        else if (arm) begin mv[k] = 1; mt[k] = arm_a[63:4]; end
      end
    end
  end

  task automatic chk(string tag, string what, int k, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s dut%0d %s cycle %0d: actual %h expected %h", tag, k, what, cyc, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    for (int k = 0; k < N_DUT; k++) begin
      chk("R2", "mem_we", k, 64'(o_we[k]), 64'(e_we[k]));
      chk("R2", "mem_addr", k, o_addr[k], e_addr[k]);
      chk("R2", "mem_data", k, 64'(o_data[k]), 64'(e_data[k]));
      chk("R2", "release", k, 64'(o_rel[k]), 64'(e_we[k]));
      chk("R1", "wb_we", k, 64'(o_wb[k]), 64'(e_wb[k]));
      chk("R1", "wb_idx", k, 64'(o_idx[k]), 64'(e_idx[k]));
      chk("R1", "wb_data", k, 64'(o_st[k]), 64'(e_st[k]));
      chk("R5", "fault", k, 64'(o_flt[k]), 64'(e_flt[k]));
      chk("R8", "undef", k, 64'(o_und[k]), 64'(e_und[k]));
    end
  endtask

  task automatic idle();
    op_v = 0; arm = 0; clr = 0; snp = 0;
  endtask

  task automatic op(logic [4:0] s, logic [4:0] t, logic [4:0] n, logic [63:0] base,
                    logic [63:0] dat);
    op_v = 1; rs = s; rt = t; rn = n; xn = base; xt = dat;
  endtask

  task automatic do_arm(logic [63:0] a);
    arm = 1; arm_a = a;
  endtask

  initial begin
    sp = 64'h1A20;
    tick(); tick();                                  // reset state
    rst_n = 1; tick();
    // R1: no reservation -> status 1
    idle(); op(5'd1, 5'd2, 5'd3, 64'h1A10, 64'hFFFF_1234); tick();
    // R2: arm then matching store -> write, status 0
    idle(); do_arm(64'h1A10); tick();
    idle(); op(5'd1, 5'd2, 5'd3, 64'h1A16, 64'hABCD_BEEF); tick();
    // R4: reservation consumed
    idle(); op(5'd1, 5'd2, 5'd3, 64'h1A16, 64'h1111); tick();
    // R3: clear and matching snoop drop it; other granule keeps it
    idle(); do_arm(64'h1A00); tick();
    idle(); clr = 1; tick();
    idle(); op(5'd4, 5'd2, 5'd3, 64'h1A00, 64'h2222); tick();
    idle(); do_arm(64'h1A00); tick();
    idle(); snp = 1; snp_a = 64'h1A08; tick();
    idle(); op(5'd4, 5'd2, 5'd3, 64'h1A02, 64'h3333); tick();
    idle(); do_arm(64'h1A00); tick();
    idle(); snp = 1; snp_a = 64'h1A30; tick();
    idle(); op(5'd4, 5'd2, 5'd3, 64'h1A02, 64'h4444); tick();
    // R3: clear beats arm in same cycle
    idle(); do_arm(64'h1A00); clr = 1; tick();
    idle(); op(5'd4, 5'd2, 5'd3, 64'h1A00, 64'h5555); tick();
    // R4: op with arm in same cycle: judged on old state, arm lost
    idle(); do_arm(64'h1A10); tick();
    idle(); op(5'd1, 5'd2, 5'd3, 64'h1A10, 64'h6666); do_arm(64'h1A10); tick();
    idle(); op(5'd1, 5'd2, 5'd3, 64'h1A10, 64'h7777); tick();
    // R5, R7: misaligned with and without reservation
    idle(); do_arm(64'h1A10); tick();
    idle(); op(5'd1, 5'd2, 5'd3, 64'h1A11, 64'h8888); tick();
    idle(); op(5'd1, 5'd2, 5'd3, 64'h1A11, 64'h8888); tick();
    // R6: stack pointer base, aligned then misaligned
    idle(); do_arm(64'h1A20); tick();
    idle(); op(5'd1, 5'd2, 5'd31, 64'h0, 64'h9999); tick();
    idle(); do_arm(64'h1A20); sp = 64'h1A28; tick();
    idle(); op(5'd1, 5'd2, 5'd31, 64'h0, 64'h9999); tick();
    sp = 64'h1A20;
    // R8, R10: status == data
    idle(); do_arm(64'h1A30); tick();
    idle(); op(5'd2, 5'd2, 5'd3, 64'h1A30, 64'hAAAA); tick();
    idle(); op(5'd2, 5'd2, 5'd3, 64'h1A30, 64'hAAAA); tick();
    // R9: status == base, unknown address lands in armed granule
    idle(); do_arm(64'h1A20); tick();
    idle(); op(5'd3, 5'd2, 5'd3, 64'h1A00, 64'hBBBB); tick();
    // R9: both overlaps; data decision first
    idle(); do_arm(64'h1A20); tick();
    idle(); op(5'd3, 5'd3, 5'd3, 64'h1A20, 64'hCCCC); tick();
    idle(); op(5'd3, 5'd1, 5'd31, 64'h0, 64'hDDDD); tick();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      idle();
      if ($urandom_range(0, 1) == 1) begin
        rs = 5'($urandom_range(0, 3)); rt = 5'($urandom_range(0, 3));
        rn = ($urandom_range(0, 4) == 4) ? 5'd31 : 5'($urandom_range(0, 3));
        xn = 64'h1A00 + 64'($urandom_range(0, 63));
        xt = {32'($urandom), 32'($urandom)};
        sp = ($urandom_range(0, 3) == 0) ? 64'h1A28 : 64'h1A20;
        op_v = 1;
      end
      if ($urandom_range(0, 9) < 3) do_arm(64'h1A00 + 64'($urandom_range(0, 63)));
      if ($urandom_range(0, 19) == 0) clr = 1;
      if ($urandom_range(0, 9) == 0) begin
        snp = 1; snp_a = 64'h1A00 + 64'($urandom_range(0, 63));
      end
      tick();
    end
    idle(); tick(); tick();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule